// File: doc/BRIEF.md
# Boot Alias Address Remapper

This block chooses which physical memory answers in the 256 KB boot window at address zero, and rewrites bus addresses so the choice takes effect. After reset it captures the boot strap inputs: the boot pin level, a software boot level with a bit that selects between pin and software, a second boot option bit, and the user-flash-empty status. From these it picks user flash, system flash or SRAM1. The same capture runs again when the chip leaves Standby.

Addresses inside the window are moved to the base of the chosen memory. All other addresses pass through unchanged, so every memory can still be reached at its physical address. After boot, software can write a new selection, which takes effect at once. A hold output stops the CPU while a boot lock request is active and during the capture cycle.

Top module: `boot_alias_remap`

## Requirements
- R1: The effective boot level is `opt_sw_level` when `opt_use_sw` is 1 and `strap_pin` otherwise. It is captured, together with `opt_boot1` and `flash_empty`, on the first clock edge after reset is released.
- R2: When the effective boot level is 0, the selection is user flash (`alias_sel` = 2'b00). If `flash_empty` was 1 at capture, it is system flash (2'b01) instead.
- R3: When the effective boot level is 1, the selection is system flash (2'b01) if `opt_boot1` is 1 and SRAM1 (2'b11) if it is 0.
- R4: After capture, changes on the strap and status inputs have no effect on `alias_sel` or `addr_o` until the next capture.
- R5: A one-cycle pulse on `standby_exit` starts a new capture on the following edge. This also replaces any selection written by software.
- R6: An address below 0x0004_0000 is output as the selected base plus the address. The bases are 0x0800_0000 for user flash, 0x1FFF_0000 for system flash and 0x2000_0000 for SRAM1.
- R7: An address at or above 0x0004_0000 is output unchanged.
- R8: `cpu_hold` is 1 whenever `lock_req` is 1. It is also 1 while a capture is pending: from reset until the capture edge, and for one cycle after a Standby exit.
- R9: When `remap_we` is 1 and no capture is pending, `remap_wdata` becomes the selection on that edge. The code 2'b10 is ignored, so the selection is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_pin | input | 1 | Boot pin level |
| opt_use_sw | input | 1 | 1: take the boot level from `opt_sw_level` |
| opt_sw_level | input | 1 | Software boot level option |
| opt_boot1 | input | 1 | Second boot option: system flash (1) or SRAM1 (0) |
| flash_empty | input | 1 | User flash contains no program |
| lock_req | input | 1 | Boot lock: hold the CPU |
| standby_exit | input | 1 | Pulse on leaving Standby |
| remap_we | input | 1 | Remap register write strobe |
| remap_wdata | input | 2 | New selection code |
| addr_i | input | 32 | Incoming bus address |
| addr_o | output | 32 | Translated address |
| cpu_hold | output | 1 | Hold the CPU |
| alias_sel | output | 2 | Current selection (remap register readback) |

## Verification
The bench uses the default parameters: a 32-bit address and an 18-bit window. With these, all 32 combinations of the five strap and status inputs can be applied through a full reset each. For every selection, the address sweep walks each of the 32 address bits and probes both edges of the window, so the boundary at 0x0004_0000 and the addition into the system flash base are both covered. All four remap codes are written, and a Standby exit is checked after a software override.

// File: rtl/boot_alias_remap.sv
module boot_alias_remap #(
  parameter int AW = 32,
  parameter int WIN_BITS = 18,
  parameter logic [AW-1:0] UF_BASE = 32'h0800_0000,
  parameter logic [AW-1:0] SF_BASE = 32'h1FFF_0000,
  parameter logic [AW-1:0] SR_BASE = 32'h2000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_pin,
  input  logic          opt_use_sw,
  input  logic          opt_sw_level,
  input  logic          opt_boot1,
  input  logic          flash_empty,
  input  logic          lock_req,
  input  logic          standby_exit,
  input  logic          remap_we,
  input  logic [1:0]    remap_wdata,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic          cpu_hold,
  output logic [1:0]    alias_sel
);
  localparam logic [1:0] SEL_UF  = 2'b00;
  localparam logic [1:0] SEL_SF  = 2'b01;
  localparam logic [1:0] SEL_BAD = 2'b10;

  logic       pend;
  logic [1:0] sel;
  logic [1:0] strap_sel;
  logic [AW-1:0] base;

  wire boot0  = opt_use_sw ? opt_sw_level : strap_pin;
  wire in_win = (addr_i[AW-1:WIN_BITS] == '0);

  always_comb begin
    if (!boot0) strap_sel = flash_empty ? SEL_SF : SEL_UF;
    else        strap_sel = opt_boot1 ? SEL_SF : 2'b11;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b1;
      sel  <= SEL_UF;
    end else if (pend) begin
      sel  <= strap_sel;
      pend <= 1'b0;
    end else if (standby_exit) begin
      pend <= 1'b1;
    end else if (remap_we && remap_wdata != SEL_BAD) begin
      sel <= remap_wdata;
    end
  end

  always_comb begin
    case (sel)
      SEL_UF:  base = UF_BASE;
      SEL_SF:  base = SF_BASE;
      default: base = SR_BASE;
    endcase
  end

  assign addr_o    = in_win ? base + addr_i : addr_i;
  assign cpu_hold  = lock_req | pend;
  assign alias_sel = sel;
endmodule

module boot_alias_remap_chk #(
  parameter int AW = 32,
  parameter int WIN_BITS = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lock_req,
  input logic          standby_exit,
  input logic          remap_we,
  input logic [1:0]    remap_wdata,
  input logic [AW-1:0] addr_i,
  input logic [AW-1:0] addr_o,
  input logic          cpu_hold,
  input logic [1:0]    alias_sel
);
  AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i[AW-1:WIN_BITS] != '0) |-> addr_o == addr_i); // R7
  AST_WINDOW_MOVED: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i[AW-1:WIN_BITS] == '0) |-> addr_o[AW-1:WIN_BITS] != '0); // R6
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    lock_req |-> cpu_hold); // R8
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    alias_sel != 2'b10); // R9
  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cpu_hold) && !$past(standby_exit) && !$past(remap_we)) |-> $stable(alias_sel)); // R4
  AST_REMAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (remap_we && remap_wdata != 2'b10 && !cpu_hold && !standby_exit) |=> alias_sel == $past(remap_wdata)); // R9
endmodule

bind boot_alias_remap boot_alias_remap_chk #(.AW(AW), .WIN_BITS(WIN_BITS)) chk (.*);

// File: tb/boot_alias_remap_test.sv
module boot_alias_remap_test;
  logic clk = 0, rst_n = 0;
  logic strap_pin = 0, opt_use_sw = 0, opt_sw_level = 0, opt_boot1 = 0, flash_empty = 0;
  logic lock_req = 0, standby_exit = 0, remap_we = 0;
  logic [1:0] remap_wdata = 0;
  logic [31:0] addr_i = 0, addr_o;
  logic cpu_hold;
  logic [1:0] alias_sel;
  int nvec = 0, nbad = 0;

  always #4 clk = ~clk;

  boot_alias_remap uut (.*);

  function automatic logic [1:0] exp_sel(logic p, logic u, logic s, logic b1, logic e);
    logic b0 = u ? s : p;
    if (!b0) return e ? 2'b01 : 2'b00;
    return b1 ? 2'b01 : 2'b11;
  endfunction

  function automatic logic [31:0] exp_addr(logic [1:0] s, logic [31:0] a);
    logic [31:0] b = (s == 2'b00) ? 32'h0800_0000 : (s == 2'b01) ? 32'h1FFF_0000 : 32'h2000_0000;
    return (a < 32'h0004_0000) ? b + a : a;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic addr_sweep(logic [1:0] s);
    logic [31:0] pts [8] = '{32'h0, 32'h4, 32'h3FFFC, 32'h3FFFF, 32'h40000,
                             32'h0800_0000, 32'h2000_0010, 32'hFFFF_FFFF};
    for (int i = 0; i < 8; i++) begin
      addr_i = pts[i]; #1;
      check(pts[i] < 32'h40000 ? "R6" : "R7", addr_o, exp_addr(s, pts[i]));
    end
    for (int i = 0; i < 32; i++) begin
      addr_i = 32'h1 << i; #1;
      check(i < 18 ? "R6" : "R7", addr_o, exp_addr(s, addr_i));
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); #1;
    check("R8 reset hold", {31'b0, cpu_hold}, 32'h1);
    rst_n = 1; #1;
    check("R8 pending hold", {31'b0, cpu_hold}, 32'h1);
    @(negedge clk); #1;
  endtask

  initial begin
    logic [1:0] e;
    for (int c = 0; c < 32; c++) begin
      {strap_pin, opt_use_sw, opt_sw_level, opt_boot1, flash_empty} = c[4:0];
      e = exp_sel(c[4], c[3], c[2], c[1], c[0]);
      do_reset();
      check(e == 2'b00 ? "R2" : (c[3] ? c[2] : c[4]) ? "R3" : "R2 empty", {30'b0, alias_sel}, {30'b0, e});
      check("R1 capture", {31'b0, cpu_hold}, 32'h0);
      addr_sweep(e);
      {strap_pin, opt_use_sw, opt_sw_level, opt_boot1, flash_empty} = ~c[4:0];
      @(negedge clk); @(negedge clk); #1;
      check("R4 held", {30'b0, alias_sel}, {30'b0, e});
      addr_i = 32'h100; #1;
      check("R4 addr", addr_o, exp_addr(e, 32'h100));
    end

    {strap_pin, opt_use_sw, opt_sw_level, opt_boot1, flash_empty} = 5'b00000;
    do_reset();
    e = 2'b00;
    for (int w = 0; w < 4; w++) begin
      @(negedge clk); remap_we = 1; remap_wdata = w[1:0];
      @(negedge clk); remap_we = 0; #1;
      if (w != 2) e = w[1:0];
      check(w == 2 ? "R9 ignored" : "R9", {30'b0, alias_sel}, {30'b0, e});
      addr_i = 32'h3_0000; #1;
      check("R9 addr", addr_o, exp_addr(e, 32'h3_0000));
    end

    strap_pin = 1; opt_boot1 = 1;
    @(negedge clk); standby_exit = 1;
    @(negedge clk); standby_exit = 0; #1;
    check("R5 pending hold", {31'b0, cpu_hold}, 32'h1);
    check("R5 not yet", {30'b0, alias_sel}, {30'b0, e});
    @(negedge clk); #1;
    check("R5", {30'b0, alias_sel}, 32'h1);
    check("R5 hold off", {31'b0, cpu_hold}, 32'h0);

    lock_req = 1; #1;
    check("R8 lock", {31'b0, cpu_hold}, 32'h1);
    @(negedge clk); @(negedge clk); #1;
    check("R8 lock held", {31'b0, cpu_hold}, 32'h1);
    lock_req = 0; #1;
    check("R8 release", {31'b0, cpu_hold}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule